// File: doc/BRIEF.md
# Watchdog Timer with Stretched Reset Generator

This block combines a software watchdog with the reset controller of a small microcontroller. A 5-bit control register chooses how long the watchdog may go without a refresh. It also chooses whether counting continues in the HALT and STOP low-power modes, and which timebase advances the counter. The timebase is either an internal RC oscillator or the crystal input. Both timebases reach the block as single-cycle tick enables in the one system clock domain. Software refreshes the watchdog by pulsing a clear strobe. If the counter reaches the selected limit before a refresh arrives, it requests a reset.

Three sources lead to one internal reset: a power-on event, an external active-low reset pin and a watchdog time-out. The pin passes through a filter that accepts it only after several consecutive low samples. The reset output comes from a two-state machine. `ST_RUN` is normal operation. `ST_HOLD` keeps the reset asserted. The machine enters `ST_HOLD` from `ST_RUN` on any trigger. It stays in `ST_HOLD` while triggers keep arriving, and each trigger reloads the hold counter. It returns to `ST_RUN` once the hold counter runs out with no trigger pending. Power-on forces `ST_HOLD` asynchronously. The control register returns to its defaults on power-on and on an accepted pin reset, but not on a watchdog time-out.

Top module: `wdt_rst_ctrl`

## Requirements
- R1: With crystal source selected (control bit 4 = 1), tap codes 00, 01, 10 and 11 in control bits [1:0] cause a time-out on the 256th, 512th, 1024th or 4096th enabled tick after a clear. The reset output rises in the cycle that follows that tick.
- R2: With RC source selected (control bit 4 = 0), the four tap codes select the limits RC_LIM0..RC_LIM3. These defaults to 50, 150, 250 and 1000 ticks, in the ratio 5:15:25:100.
- R3: Control bit 4 selects the counting tick. A value of 0 takes rc_tick and ignores xtal_tick. A value of 1 takes xtal_tick and ignores rc_tick.
- R4: While halt_mode is high, counting proceeds only if control bit 2 is 1. When counting is blocked, the count is held and is not cleared, and it resumes from that value when halt_mode falls.
- R5: While stop_mode is high, counting proceeds only if control bit 3 is 1 and the RC source is selected. The crystal source never counts in STOP. stop_mode takes precedence over halt_mode.
- R6: A wdt_clr pulse returns the count to zero, so that a full limit of ticks is needed again.
- R7: The reset pin is accepted only after it has been sampled low on 4 consecutive clocks. A low pulse of 3 clocks has no effect.
- R8: The reset output goes high in the clock after a trigger and stays high until 18 clocks after the last trigger. Power-on holds it high, and it stays high for 18 clocks after power-on is released.
- R9: Power-on and an accepted pin reset load the control register with 5'b01100: tap 00, HALT enable 1, STOP enable 1, RC source. A watchdog time-out leaves the register unchanged.
- R10: A write with cfg_we updates cfg_q in the next clock while the reset output is low. While the reset output is high, writes are ignored.
- R11: The count is held at zero while the reset output is high. After release, a full limit of ticks is needed for the next time-out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por | input | 1 | Power-on event, active high, asynchronous |
| rst_pin_n | input | 1 | External reset pin, active low |
| xtal_tick | input | 1 | Crystal timebase tick enable |
| rc_tick | input | 1 | RC oscillator timebase tick enable |
| halt_mode | input | 1 | Core is in HALT mode |
| stop_mode | input | 1 | Core is in STOP mode |
| wdt_clr | input | 1 | Software refresh strobe |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 5 | Control data: [4] source, [3] STOP enable, [2] HALT enable, [1:0] tap |
| cfg_q | output | 5 | Current control register value |
| rst_out | output | 1 | Stretched internal reset, active high |

## Verification
The assertions check rules that hold on every cycle:
- A trigger always leads to reset in the next clock.
- Reset never falls in a cycle that had a trigger.
- A clear or a held reset zeroes the count.
- The crystal source keeps the count frozen in STOP.
- A pin acceptance is preceded by a low pin sample.
- The control register is stable during reset unless a pin reset reloads it.

Only the bench scenarios can show the exact tick count for every tap and source, the resumption of a held count after HALT, the rejection of a 3-clock pin pulse, the full 18-clock stretch measured from the last trigger, and that a time-out keeps the configuration.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef struct packed {
        logic       src;      // 1: crystal tick, 0: RC tick
        logic       stop_en;  // count while in STOP
        logic       halt_en;  // count while in HALT
        logic [1:0] tap;      // time-out select
    } wdt_cfg_t;

    localparam wdt_cfg_t CFG_DEFAULT = '{src: 1'b0, stop_en: 1'b1, halt_en: 1'b1, tap: 2'b00};

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HOLD = 1'b1
    } hold_state_e;

endpackage

// File: rtl/wdt_pin_filter.sv
module wdt_pin_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic por,
    input  logic pin_n,
    output logic accept
);
    localparam int FW = $clog2(FILT_LEN + 1);

    logic [FW-1:0] low_cnt;

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            low_cnt <= '0;
        end else if (pin_n) begin
            low_cnt <= '0;
        end else if (low_cnt != FW'(FILT_LEN)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign accept = (low_cnt == FW'(FILT_LEN));

    // R7
    pin_low_seen_chk: assert property (@(posedge clk) disable iff (por)
        $rose(accept) |-> $past(!pin_n));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int XT_LIM0 = 256,
    parameter int XT_LIM1 = 512,
    parameter int XT_LIM2 = 1024,
    parameter int XT_LIM3 = 4096,
    parameter int RC_LIM0 = 50,
    parameter int RC_LIM1 = 150,
    parameter int RC_LIM2 = 250,
    parameter int RC_LIM3 = 1000
) (
    input  logic     clk,
    input  logic     por,
    input  wdt_cfg_t cfg,
    input  logic     xtal_tick,
    input  logic     rc_tick,
    input  logic     halt_mode,
    input  logic     stop_mode,
    input  logic     clr,
    input  logic     hold,
    output logic     timeout
);
    localparam int MAXL = (XT_LIM3 > RC_LIM3) ? XT_LIM3 : RC_LIM3;
    localparam int CW   = $clog2(MAXL);

    logic [CW-1:0] cnt;
    logic [CW:0]   lim;
    logic          tick;
    logic          gate;
    logic          adv;
    logic          at_lim;

    always_comb begin
        unique case ({cfg.src, cfg.tap})
            3'b100:  lim = (CW+1)'(XT_LIM0);
            3'b101:  lim = (CW+1)'(XT_LIM1);
            3'b110:  lim = (CW+1)'(XT_LIM2);
            3'b111:  lim = (CW+1)'(XT_LIM3);
            3'b000:  lim = (CW+1)'(RC_LIM0);
            3'b001:  lim = (CW+1)'(RC_LIM1);
            3'b010:  lim = (CW+1)'(RC_LIM2);
            default: lim = (CW+1)'(RC_LIM3);
        endcase
    end

    always_comb begin
        tick = cfg.src ? xtal_tick : rc_tick;
        if (stop_mode)      gate = cfg.stop_en & ~cfg.src;
        else if (halt_mode) gate = cfg.halt_en;
        else                gate = 1'b1;
        adv    = tick & gate;
        at_lim = ({1'b0, cnt} >= (lim - 1'b1));
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            cnt <= '0;
        end else if (hold || clr) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= at_lim ? '0 : cnt + 1'b1;
        end
    end

    assign timeout = adv & at_lim & ~hold & ~clr;

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (por)
        (clr && !hold) |=> (cnt == '0));

    // R11
    hold_zero_chk: assert property (@(posedge clk) disable iff (por)
        hold |=> (cnt == '0));

    // R5
    stop_xtal_frozen_chk: assert property (@(posedge clk) disable iff (por)
        (stop_mode && cfg.src && !clr && !hold) |=> $stable(cnt));

    // R1
    timeout_restart_chk: assert property (@(posedge clk) disable iff (por)
        timeout |=> (cnt == '0));

endmodule

// File: rtl/wdt_stretch.sv
module wdt_stretch
    import wdt_pkg::*;
#(
    parameter int STRETCH = 18
) (
    input  logic clk,
    input  logic por,
    input  logic trig,
    output logic busy
);
    localparam int SW = $clog2(STRETCH);

    hold_state_e   state, state_nxt;
    logic [SW-1:0] hcnt, hcnt_nxt;

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            state <= ST_HOLD;
            hcnt  <= SW'(STRETCH - 1);
        end else begin
            state <= state_nxt;
            hcnt  <= hcnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        hcnt_nxt  = hcnt;
        unique case (state)
            ST_RUN: begin
                if (trig) begin
                    state_nxt = ST_HOLD;
                    hcnt_nxt  = SW'(STRETCH - 1);
                end
            end
            ST_HOLD: begin
                if (trig) begin
                    hcnt_nxt = SW'(STRETCH - 1);
                end else if (hcnt == '0) begin
                    state_nxt = ST_RUN;
                end else begin
                    hcnt_nxt = hcnt - 1'b1;
                end
            end
            default: state_nxt = ST_HOLD;
        endcase
    end

    always_comb begin
        busy = (state == ST_HOLD);
    end

    // R8
    trig_asserts_chk: assert property (@(posedge clk) disable iff (por)
        trig |=> busy);

    // R8
    no_early_release_chk: assert property (@(posedge clk) disable iff (por)
        $fell(busy) |-> $past(!trig));

endmodule

// File: rtl/wdt_rst_ctrl.sv
module wdt_rst_ctrl
    import wdt_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int STRETCH  = 18,
    parameter int XT_LIM0  = 256,
    parameter int XT_LIM1  = 512,
    parameter int XT_LIM2  = 1024,
    parameter int XT_LIM3  = 4096,
    parameter int RC_LIM0  = 50,
    parameter int RC_LIM1  = 150,
    parameter int RC_LIM2  = 250,
    parameter int RC_LIM3  = 1000
) (
    input  logic       clk,
    input  logic       por,
    input  logic       rst_pin_n,
    input  logic       xtal_tick,
    input  logic       rc_tick,
    input  logic       halt_mode,
    input  logic       stop_mode,
    input  logic       wdt_clr,
    input  logic       cfg_we,
    input  logic [4:0] cfg_wdata,
    output logic [4:0] cfg_q,
    output logic       rst_out
);
    wdt_cfg_t cfg;
    logic     pin_acc;
    logic     tmo;
    logic     busy;

    wdt_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk    (clk),
        .por    (por),
        .pin_n  (rst_pin_n),
        .accept (pin_acc)
    );

    wdt_counter #(
        .XT_LIM0(XT_LIM0), .XT_LIM1(XT_LIM1), .XT_LIM2(XT_LIM2), .XT_LIM3(XT_LIM3),
        .RC_LIM0(RC_LIM0), .RC_LIM1(RC_LIM1), .RC_LIM2(RC_LIM2), .RC_LIM3(RC_LIM3)
    ) u_cnt (
        .clk       (clk),
        .por       (por),
        .cfg       (cfg),
        .xtal_tick (xtal_tick),
        .rc_tick   (rc_tick),
        .halt_mode (halt_mode),
        .stop_mode (stop_mode),
        .clr       (wdt_clr),
        .hold      (busy),
        .timeout   (tmo)
    );

    wdt_stretch #(.STRETCH(STRETCH)) u_str (
        .clk  (clk),
        .por  (por),
        .trig (pin_acc | tmo),
        .busy (busy)
    );

    always_ff @(posedge clk or posedge por) begin
        if (por) begin
            cfg <= CFG_DEFAULT;
        end else if (pin_acc) begin
            cfg <= CFG_DEFAULT;
        end else if (cfg_we && !busy) begin
            cfg <= wdt_cfg_t'(cfg_wdata);
        end
    end

    assign cfg_q   = cfg;
    assign rst_out = busy;

    // R10
    cfg_locked_chk: assert property (@(posedge clk) disable iff (por)
        (rst_out && !pin_acc) |=> $stable(cfg_q));

    // R9
    pin_default_chk: assert property (@(posedge clk) disable iff (por)
        pin_acc |=> (cfg_q == 5'b01100));

endmodule

// File: tb/wdt_rst_ctrl_tb.sv
module wdt_rst_ctrl_tb;

    typedef struct {
        string      req;
        bit         is_cfg;
        logic [4:0] exp;
    } item_t;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       rst_pin_n = 1'b1;
    logic       xtal_tick = 1'b1;
    logic       rc_tick = 1'b1;
    logic       halt_mode = 1'b0;
    logic       stop_mode = 1'b0;
    logic       wdt_clr = 1'b0;
    logic       cfg_we = 1'b0;
    logic [4:0] cfg_wdata = 5'b0;
    logic [4:0] cfg_q;
    logic       rst_out;

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    item_t q[$];

    wdt_rst_ctrl u_dut (
        .clk(clk), .por(por), .rst_pin_n(rst_pin_n), .xtal_tick(xtal_tick),
        .rc_tick(rc_tick), .halt_mode(halt_mode), .stop_mode(stop_mode),
        .wdt_clr(wdt_clr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_q(cfg_q), .rst_out(rst_out)
    );

    always #2.5ns clk = ~clk;

    // monitor: compares queued expectations half a cycle after each edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [4:0] act;
            it = q.pop_front();
            act = it.is_cfg ? cfg_q : {4'b0, rst_out};
            n_run++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s %s actual=%b expected=%b at %0t",
                         it.req, it.is_cfg ? "cfg_q" : "rst_out", act, it.exp, $time);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1ns;
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic exp_rst(string req, logic v);
        item_t it;
        it.req = req; it.is_cfg = 1'b0; it.exp = {4'b0, v};
        q.push_back(it);
    endtask

    task automatic exp_cfg(string req, logic [4:0] v);
        item_t it;
        it.req = req; it.is_cfg = 1'b1; it.exp = v;
        q.push_back(it);
    endtask

    task automatic write_cfg(string req, logic [4:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        step();
        cfg_we = 1'b0;
        exp_cfg(req, v);
    endtask

    task automatic clear();
        wdt_clr = 1'b1;
        step();
        wdt_clr = 1'b0;
    endtask

    // time-out expected on the n-th tick edge from now
    task automatic tmo_at(string req, int n);
        steps(n - 1);
        exp_rst(req, 1'b0);
        step();
        exp_rst(req, 1'b1);
    endtask

    // the current edge was the last trigger: 17 more high, then low
    task automatic ride_out(string req);
        steps(17);
        exp_rst(req, 1'b1);
        step();
        exp_rst(req, 1'b0);
    endtask

    task automatic tap_case(string req, logic [4:0] v, int lim);
        write_cfg(req, v);
        clear();
        tmo_at(req, lim);
        ride_out(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R8 R9: power-on state and stretch after release
        steps(3);
        exp_rst("R8", 1'b1);
        exp_cfg("R9", 5'b01100);
        por = 1'b0;
        steps(17);
        exp_rst("R8", 1'b1);
        step();
        exp_rst("R8", 1'b0);

        // R1 crystal taps, R10 write, R9 timeout keeps cfg
        write_cfg("R10", 5'b11100);
        clear();
        tmo_at("R1", 256);
        exp_cfg("R9", 5'b11100);
        ride_out("R8");
        tmo_at("R11", 256);
        ride_out("R11");
        tap_case("R1", 5'b11101, 512);
        tap_case("R1", 5'b11110, 1024);
        tap_case("R1", 5'b11111, 4096);

        // R6 refresh keeps reset away
        write_cfg("R6", 5'b11100);
        clear();
        for (int k = 0; k < 5; k++) begin
            steps(200);
            clear();
        end
        exp_rst("R6", 1'b0);
        tmo_at("R6", 256);
        ride_out("R6");

        // R4 halt blocks and holds the count
        write_cfg("R4", 5'b11000);
        clear();
        steps(100);
        halt_mode = 1'b1;
        steps(500);
        exp_rst("R4", 1'b0);
        halt_mode = 1'b0;
        tmo_at("R4", 156);
        ride_out("R4");
        write_cfg("R4", 5'b11100);
        clear();
        halt_mode = 1'b1;
        tmo_at("R4", 256);
        halt_mode = 1'b0;
        ride_out("R4");

        // R5 stop gating
        write_cfg("R5", 5'b11100);
        clear();
        stop_mode = 1'b1;
        steps(600);
        exp_rst("R5", 1'b0);
        stop_mode = 1'b0;
        tmo_at("R5", 256);
        ride_out("R5");
        write_cfg("R5", 5'b01100);
        clear();
        stop_mode = 1'b1;
        tmo_at("R5", 50);
        stop_mode = 1'b0;
        ride_out("R5");
        write_cfg("R5", 5'b00100);
        clear();
        stop_mode = 1'b1;
        halt_mode = 1'b1;
        steps(300);
        exp_rst("R5", 1'b0);
        stop_mode = 1'b0;
        halt_mode = 1'b0;
        tmo_at("R5", 50);
        ride_out("R5");

        // R2 RC taps
        tap_case("R2", 5'b01101, 150);
        tap_case("R2", 5'b01110, 250);
        tap_case("R2", 5'b01111, 1000);

        // R3 source select
        rc_tick = 1'b0;
        write_cfg("R3", 5'b01100);
        clear();
        steps(300);
        exp_rst("R3", 1'b0);
        xtal_tick = 1'b0;
        rc_tick = 1'b1;
        write_cfg("R3", 5'b11100);
        clear();
        steps(300);
        exp_rst("R3", 1'b0);
        xtal_tick = 1'b1;
        rc_tick = 1'b0;
        clear();
        tmo_at("R3", 256);
        ride_out("R3");
        rc_tick = 1'b1;

        // R7 pin filter, R9 defaults, R10 write lock
        write_cfg("R7", 5'b11111);
        clear();
        rst_pin_n = 1'b0;
        steps(3);
        rst_pin_n = 1'b1;
        steps(10);
        exp_rst("R7", 1'b0);
        exp_cfg("R7", 5'b11111);
        rst_pin_n = 1'b0;
        steps(4);
        exp_rst("R7", 1'b0);
        step();
        exp_rst("R7", 1'b1);
        exp_cfg("R9", 5'b01100);
        rst_pin_n = 1'b1;
        step();
        cfg_we = 1'b1; cfg_wdata = 5'b11111;
        step();
        cfg_we = 1'b0;
        exp_cfg("R10", 5'b01100);
        steps(16);
        exp_rst("R8", 1'b1);
        step();
        exp_rst("R8", 1'b0);
        exp_cfg("R10", 5'b01100);

        steps(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule